// File: doc/BRIEF.md
# Segment:Offset Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address inside a 1 MB space. The segment value is scaled by sixteen, which is a left shift by four bits. The offset is then added to it, and any carry beyond the top address bit is dropped.

The caller supplies the current contents of four segment registers: code, data, stack and extra. It also supplies an access type, and the block uses that type to pick which register acts as the segment. An override path lets the caller name the segment register directly. The result is captured in an output register together with a valid flag, one clock after the request is presented.

Top module: `seg_agu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_q` becomes 0 and `addr_valid` becomes 0 after that edge.
- R2: A request produces `addr_q` = (segment << 4) + offset, kept to the low 20 bits. For example, segment 6020h with offset 4267h gives 64467h.
- R3: A carry out of bit 19 is dropped. Segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: With `ovr_en` = 0 and `acc_type` = 0 (instruction fetch), the code segment `seg_cs` is used.
- R5: With `ovr_en` = 0 and `acc_type` = 1 (data), the data segment `seg_ds` is used.
- R6: With `ovr_en` = 0 and `acc_type` = 2 (stack), the stack segment `seg_ss` is used.
- R7: With `ovr_en` = 0 and `acc_type` = 3 (string destination), the extra segment `seg_es` is used.
- R8: With `ovr_en` = 1, `ovr_sel` picks the segment whatever the access type: 0 = `seg_es`, 1 = `seg_cs`, 2 = `seg_ss`, 3 = `seg_ds`. With `ovr_en` = 0, `ovr_sel` has no effect.
- R9: `addr_valid` is high in exactly the cycle after a clock edge at which `req_valid` was high, and low after an edge at which `req_valid` was low.
- R10: Different pairs that name the same byte give the same address. 0000:0300, 0001:02F0 and 0030:0000 all give 00300h.
- R11: After an edge at which `req_valid` is low, `addr_q` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A translation request is presented this cycle |
| acc_type | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default segment |
| ovr_sel | input | 2 | Segment named by the override: 0 extra, 1 code, 2 stack, 3 data |
| seg_cs | input | 16 | Code segment value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| offset | input | 16 | Byte offset within the segment |
| addr_q | output | 20 | Registered physical address |
| addr_valid | output | 1 | `addr_q` holds a new result |

## Verification
The bench uses the default parameters: 16-bit segment and offset, a 4-bit shift, and therefore a 20-bit address. With these values the top-of-space wrap at FFFF:FFFF can be reached directly, as can the byte-aliasing cases at 00300h. The four segment inputs are given distinct values, so choosing the wrong register shows up in the upper address nibbles. This covers every default and every override code.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_DATA   = 2'd1,
    ACC_STACK  = 2'd2,
    ACC_STRDST = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_sel_t;

  localparam int NUM_SEGS = 4;
endpackage

// File: rtl/seg_default_sel.sv
module seg_default_sel
  import seg_agu_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  output logic [1:0] sel
);
  acc_t acc;
  seg_sel_t dflt;

  assign acc = acc_t'(acc_type);

  always_comb begin
    unique case (acc)
      ACC_FETCH:  dflt = SEG_CS;
      ACC_DATA:   dflt = SEG_DS;
      ACC_STACK:  dflt = SEG_SS;
      ACC_STRDST: dflt = SEG_ES;
      default:    dflt = SEG_DS;
    endcase
  end

  assign sel = ovr_en ? ovr_sel : dflt;
endmodule

// File: rtl/seg_value_mux.sv
module seg_value_mux #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic [SEG_W-1:0] segs [NSEG],
  input  logic [SEL_W-1:0] sel,
  output logic [SEG_W-1:0] seg_out
);
  logic [NSEG-1:0] hit;
  logic [SEG_W-1:0] masked [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_way
    assign hit[i] = (sel == SEL_W'(i));
    assign masked[i] = hit[i] ? segs[i] : '0;
  end

  always_comb begin
    seg_out = '0;
    for (int i = 0; i < NSEG; i++) seg_out = seg_out | masked[i];
  end
endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs_ext;

  assign base    = {seg, {SHIFT{1'b0}}};
  assign ofs_ext = ADDR_W'(ofs);
  assign addr    = base + ofs_ext;
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        acc_type,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ds,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_valid
);
  logic [1:0]        sel;
  logic [SEG_W-1:0]  segs [NUM_SEGS];
  logic [SEG_W-1:0]  seg_pick;
  logic [ADDR_W-1:0] addr_d;

  assign segs[SEG_ES] = seg_es;
  assign segs[SEG_CS] = seg_cs;
  assign segs[SEG_SS] = seg_ss;
  assign segs[SEG_DS] = seg_ds;

  seg_default_sel u_sel (
    .acc_type (acc_type),
    .ovr_en   (ovr_en),
    .ovr_sel  (ovr_sel),
    .sel      (sel)
  );

  seg_value_mux #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_mux (
    .segs    (segs),
    .sel     (sel),
    .seg_out (seg_pick)
  );

  seg_addr_add #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
    .seg  (seg_pick),
    .ofs  (offset),
    .addr (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        acc_type,
  input logic              ovr_en,
  input logic [1:0]        ovr_sel,
  input logic [SEG_W-1:0]  seg_cs,
  input logic [SEG_W-1:0]  seg_ds,
  input logic [SEG_W-1:0]  seg_ss,
  input logic [SEG_W-1:0]  seg_es,
  input logic [OFS_W-1:0]  offset,
  input logic [ADDR_W-1:0] addr_q,
  input logic              addr_valid
);
  function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] s,
                                             input logic [OFS_W-1:0] o);
    logic [ADDR_W+1:0] full;
    full = ((ADDR_W+2)'(s) << SHIFT) + (ADDR_W+2)'(o);
    return full[ADDR_W-1:0];
  endfunction

  // R9: valid follows the request by one cycle
  a_r9_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid);

  // R11: address holds when idle
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(addr_q));

  // R4, R2: fetch uses the code segment
  a_r4_fetch_cs: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && acc_type == 2'd0) |=>
      addr_q == phys($past(seg_cs), $past(offset)));

  // R5
  a_r5_data_ds: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && acc_type == 2'd1) |=>
      addr_q == phys($past(seg_ds), $past(offset)));

  // R6
  a_r6_stack_ss: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && acc_type == 2'd2) |=>
      addr_q == phys($past(seg_ss), $past(offset)));

  // R7
  a_r7_strdst_es: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && acc_type == 2'd3) |=>
      addr_q == phys($past(seg_es), $past(offset)));

  // R8: override to the extra segment, from any access type
  a_r8_ovr_es: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ovr_en && ovr_sel == 2'd0) |=>
      addr_q == phys($past(seg_es), $past(offset)));
  a_r8_ovr_ds: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ovr_en && ovr_sel == 2'd3) |=>
      addr_q == phys($past(seg_ds), $past(offset)));
endmodule

bind seg_agu seg_agu_chk #(
  .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .acc_type(acc_type),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .seg_cs(seg_cs), .seg_ds(seg_ds),
  .seg_ss(seg_ss), .seg_es(seg_es), .offset(offset),
  .addr_q(addr_q), .addr_valid(addr_valid)
);

// File: tb/sim_seg_agu.sv
module sim_seg_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_type = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0, offset = '0;
  logic [19:0] addr_q;
  logic        addr_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_agu u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .acc_type(acc_type),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .seg_cs(seg_cs), .seg_ds(seg_ds),
    .seg_ss(seg_ss), .seg_es(seg_es), .offset(offset),
    .addr_q(addr_q), .addr_valid(addr_valid)
  );

  // {acc, ovr_en, ovr_sel, cs, ds, ss, es, ofs, expected}
  localparam int NV = 12;
  localparam logic [104:0] VEC [NV] = '{
    {2'd0,1'b0,2'd0,16'h6020,16'h2000,16'h3000,16'h4000,16'h4267,20'h64467}, // R2 R4
    {2'd1,1'b0,2'd0,16'h1000,16'h0001,16'h3000,16'h4000,16'h02F0,20'h00300}, // R5 R10
    {2'd1,1'b0,2'd0,16'h1000,16'h0030,16'h3000,16'h4000,16'h0000,20'h00300}, // R10
    {2'd1,1'b0,2'd0,16'h1000,16'h0000,16'h3000,16'h4000,16'h0300,20'h00300}, // R10
    {2'd2,1'b0,2'd0,16'h1000,16'h2000,16'h3000,16'h4000,16'h0010,20'h30010}, // R6
    {2'd3,1'b0,2'd0,16'h1000,16'h2000,16'h3000,16'h4000,16'h1234,20'h41234}, // R7
    {2'd0,1'b0,2'd0,16'hFFFF,16'h2000,16'h3000,16'h4000,16'hFFFF,20'h0FFEF}, // R3
    {2'd1,1'b1,2'd1,16'h1000,16'h2000,16'h3000,16'h4000,16'h0005,20'h10005}, // R8 CS
    {2'd0,1'b1,2'd0,16'h1000,16'h2000,16'h3000,16'h4000,16'h0000,20'h40000}, // R8 ES
    {2'd2,1'b1,2'd3,16'h1000,16'h2000,16'h3000,16'h4000,16'h00FF,20'h200FF}, // R8 DS
    {2'd3,1'b1,2'd2,16'h1000,16'h2000,16'h3000,16'h4000,16'h8000,20'h38000}, // R8 SS
    {2'd1,1'b0,2'd2,16'h1000,16'h2000,16'h3000,16'h4000,16'h0001,20'h20001}  // R8 ignored
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [19:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid", {19'd0, addr_valid}, 20'd0);
    check("R1 addr", addr_q, 20'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {acc_type, ovr_en, ovr_sel, seg_cs, seg_ds, seg_ss, seg_es, offset} = VEC[i][104:20];
      req_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R2 vec%0d addr", i), addr_q, VEC[i][19:0]);
      check("R9 valid high", {19'd0, addr_valid}, 20'd1);
    end

    // R9 R11: idle cycle with changing inputs
    held = addr_q;
    req_valid = 1'b0;
    seg_ds = 16'hABCD; offset = 16'h1111; acc_type = 2'd1;
    @(negedge clk);
    check("R9 valid low", {19'd0, addr_valid}, 20'd0);
    check("R11 hold", addr_q, held);
    @(negedge clk);
    check("R11 hold 2", addr_q, held);

    // R9 back-to-back requests
    req_valid = 1'b1; acc_type = 2'd2; ovr_en = 1'b0; seg_ss = 16'h0100; offset = 16'h0002;
    @(negedge clk);
    check("R6 b2b first", addr_q, 20'h01002);
    acc_type = 2'd0; seg_cs = 16'hF000; offset = 16'hFFF0;
    @(negedge clk);
    check("R4 b2b second", addr_q, 20'hFFFF0);
    check("R9 b2b valid", {19'd0, addr_valid}, 20'd1);

    // R1 reset mid-run, with a request present
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid valid", {19'd0, addr_valid}, 20'd0);
    check("R1 mid addr", addr_q, 20'd0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule